// File: doc/BRIEF.md
# Asymmetric I2C SCL Phase Generator

This block produces the serial clock for an I2C master together with a one-cycle strobe that marks the moment when the data line may safely change. The low and high parts of each SCL period are set separately, in units of eight system clocks. A 32-bit control word carries both settings: the upper half sets the high phase and the lower half sets the low phase.

The strobe fires in the middle of every low phase, so data always changes well away from both SCL edges. Software writes a new divider word at any time. The word is held in a pending register and is copied into the active pair only when a new low phase begins. Because of this, a phase that has already started always runs to its full length.

Clearing the enable input parks SCL high at once and clears the counters. Setting it starts a fresh period with a low phase. The register port is a plain write strobe with no back-pressure: it is always ready, and a later write replaces an earlier one that has not yet been applied.

Top module: `scl_phase_gen`

## Requirements
- R1: While `en` is sampled low, `scl_o` is 1 from the next cycle on and `sda_upd_o` stays 0.
- R2: On the first clock edge that samples `en` high after a disabled period, `scl_o` goes to 0, so every run starts with a low phase.
- R3: A low phase lasts 8*(L+1) system clocks, where L is bits 15:0 of the applied divider word.
- R4: A high phase lasts 8*(H+1) system clocks, where H is bits 31:16 of the applied divider word.
- R5: In every low phase, `sda_upd_o` is 1 for exactly one cycle, 4*(L+1) cycles after the first low cycle (the first low cycle is offset 0). It is never 1 while `scl_o` is 1.
- R6: A word written after a low phase has begun does not change that low phase or the high phase that follows it. The word applies from the next low phase on.
- R7: A word written on the same clock edge on which a low phase begins does not apply to that period. It applies to the period after.
- R8: A word written while `en` is low is used from the first phase after enabling.
- R9: After reset the pending word is 0, so the first period is 8 cycles low and 8 cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low parks SCL high |
| cfg_wdata | input | 32 | Divider word: high setting in 31:16, low setting in 15:0 |
| cfg_we | input | 1 | One-cycle write strobe for `cfg_wdata` |
| scl_o | output | 1 | Generated serial clock |
| sda_upd_o | output | 1 | One-cycle strobe at mid low phase |

## Verification
The delicate case is a divider write that lands on the same clock edge on which the active pair is reloaded at a falling SCL edge. The bench tracks its own position in the period and drives the write in the last high cycle, so the write and the reload fall on the same edge. The lengths of the next two periods are then measured. The first must still show the old settings and the second the new ones. A write in the middle of a low phase and a write during a high phase are judged the same way.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_t;
endpackage

// File: rtl/scl_div_regs.sv
`timescale 1ns/1ps
module scl_div_regs #(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2*DIV_W-1:0] wr_data,
  input  logic               load,
  output logic [DIV_W-1:0]   div_lo,
  output logic [DIV_W-1:0]   div_hi
);
  localparam int NFIELD = 2;

  logic [DIV_W-1:0] pend [NFIELD];
  logic [DIV_W-1:0] act  [NFIELD];

  // field 0 = low phase (bits DIV_W-1:0), field 1 = high phase (upper bits)
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= '0;
        act[g]  <= '0;
      end else begin
        if (wr_en) pend[g] <= wr_data[g*DIV_W +: DIV_W];
        if (load)  act[g]  <= pend[g];
      end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(act[g])); // R6
  end

  assign div_lo = act[0];
  assign div_hi = act[1];
endmodule

// File: rtl/scl_phase_cnt.sv
`timescale 1ns/1ps
module scl_phase_cnt
  import scl_gen_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int UNIT_LOG2 = 3,
  localparam int CW       = DIV_W + UNIT_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_lo,
  input  logic [DIV_W-1:0] div_hi,
  output logic             scl,
  output logic             low_run,
  output logic [CW-1:0]    cnt,
  output logic             load
);
  phase_t           ph_q;
  logic             run_q;
  logic [CW-1:0]    cnt_q;
  logic [DIV_W-1:0] cur_div;
  logic [CW-1:0]    term;
  logic             at_end;

  assign cur_div = (ph_q == PH_LOW) ? div_lo : div_hi;
  assign term    = {cur_div, {UNIT_LOG2{1'b1}}};
  assign at_end  = (cnt_q == term);
  // active pair reloads when a low phase is about to begin
  assign load    = en && (!run_q || (ph_q == PH_HIGH && at_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      ph_q  <= PH_LOW;
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign scl     = (ph_q == PH_HIGH);
  assign low_run = run_q && (ph_q == PH_LOW);
  assign cnt     = cnt_q;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && cnt_q == '0)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= term)); // R3
  AST_EDGE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && !at_end) |=> $stable(ph_q)); // R4
endmodule

// File: rtl/scl_mid_strobe.sv
`timescale 1ns/1ps
module scl_mid_strobe #(
  parameter int DIV_W     = 16,
  parameter int UNIT_LOG2 = 3,
  localparam int CW       = DIV_W + UNIT_LOG2
) (
  input  logic             low_run,
  input  logic [CW-1:0]    cnt,
  input  logic [DIV_W-1:0] div_lo,
  output logic             strobe
);
  logic [CW-1:0] half;

  // half of 2^UNIT_LOG2 * (div_lo + 1)
  assign half   = (CW'(div_lo) + CW'(1)) << (UNIT_LOG2 - 1);
  assign strobe = low_run && (cnt == half);
endmodule

// File: rtl/scl_phase_gen.sv
`timescale 1ns/1ps
module scl_phase_gen #(
  parameter int DIV_W     = 16,
  parameter int UNIT_LOG2 = 3,
  localparam int CW       = DIV_W + UNIT_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [2*DIV_W-1:0] cfg_wdata,
  input  logic               cfg_we,
  output logic               scl_o,
  output logic               sda_upd_o
);
  logic [DIV_W-1:0] div_lo, div_hi;
  logic             load, low_run;
  logic [CW-1:0]    cnt;

  scl_div_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .load(load), .div_lo(div_lo), .div_hi(div_hi)
  );

  scl_phase_cnt #(.DIV_W(DIV_W), .UNIT_LOG2(UNIT_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .div_lo(div_lo), .div_hi(div_hi),
    .scl(scl_o), .low_run(low_run), .cnt(cnt), .load(load)
  );

  scl_mid_strobe #(.DIV_W(DIV_W), .UNIT_LOG2(UNIT_LOG2)) u_strb (
    .low_run(low_run), .cnt(cnt), .div_lo(div_lo), .strobe(sda_upd_o)
  );

  AST_STROBE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_o |-> !scl_o); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_o |=> !sda_upd_o); // R5
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> !scl_o); // R2
endmodule

// File: tb/scl_phase_gen_test.sv
`timescale 1ns/1ps
module scl_phase_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic        scl_o, sda_upd_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  scl_phase_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .scl_o(scl_o), .sda_upd_o(sda_upd_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the negedge of the first low cycle; returns at the next one.
  task automatic measure(output int lo, output int hi, output int soff,
                         output int scnt, output int shigh,
                         input int wr_at, input logic [31:0] wr_d);
    int k = 0;
    lo = 0; hi = 0; soff = -1; scnt = 0; shigh = 0;
    while (scl_o == 1'b0) begin
      if (sda_upd_o) begin scnt++; if (soff < 0) soff = lo; end
      if (k == wr_at) begin cfg_wdata = wr_d; cfg_we = 1'b1; end
      lo++; k++;
      @(negedge clk); cfg_we = 1'b0;
    end
    while (scl_o == 1'b1) begin
      if (sda_upd_o) shigh++;
      if (k == wr_at) begin cfg_wdata = wr_d; cfg_we = 1'b1; end
      hi++; k++;
      @(negedge clk); cfg_we = 1'b0;
    end
  endtask

  task automatic write_idle(input int l, input int h);
    cfg_wdata = {16'(h), 16'(l)}; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic start_run();
    en = 1'b1;
    @(negedge clk);
    chk("R2 scl low after enable", int'(scl_o), 0);
  endtask

  task automatic stop_run();
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_period(input string tag, input int l, input int h,
                               input int wr_at, input logic [31:0] wr_d);
    int lo, hi, soff, scnt, shigh;
    measure(lo, hi, soff, scnt, shigh, wr_at, wr_d);
    chk({tag, " R3 low length"}, lo, 8 * (l + 1));
    chk({tag, " R4 high length"}, hi, 8 * (h + 1));
    chk({tag, " R5 strobe offset"}, soff, 4 * (l + 1));
    chk({tag, " R5 strobe count"}, scnt, 1);
    chk({tag, " R5 no strobe high"}, shigh, 0);
  endtask

  task automatic t_reset();
    chk("R1 scl idle after reset", int'(scl_o), 1);
    chk("R1 no strobe after reset", int'(sda_upd_o), 0);
    start_run();
    expect_period("R9 reset word", 0, 0, -1, '0);
    stop_run();
  endtask

  task automatic t_disable();
    int s1 = 0, st = 0;
    start_run();
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R1 scl high after disable", int'(scl_o), 1);
    for (int i = 0; i < 40; i++) begin
      if (scl_o) s1++;
      if (sda_upd_o) st++;
      @(negedge clk);
    end
    chk("R1 scl stays high", s1, 40);
    chk("R1 no strobe while off", st, 0);
  endtask

  task automatic t_asym(input int l, input int h);
    write_idle(l, h);
    start_run();
    expect_period("R8 first", l, h, -1, '0);
    expect_period("R3 R4 second", l, h, -1, '0);
    stop_run();
  endtask

  task automatic t_mid_write();
    write_idle(3, 2);
    start_run();
    // write inside low phase (cycle 5 of a 32-cycle low)
    expect_period("R6 low write, old", 3, 2, 5, {16'd4, 16'd1});
    // write inside high phase (cycle 16 + 2)
    expect_period("R6 new applies", 1, 4, 18, {16'd0, 16'd2});
    expect_period("R6 high write applies", 2, 0, -1, '0);
    stop_run();
  endtask

  task automatic t_edge_write();
    write_idle(1, 1);
    start_run();
    // last high cycle index 31: write lands on the reload edge
    expect_period("R7 before", 1, 1, 31, {16'd0, 16'd4});
    expect_period("R7 same-edge period", 1, 1, -1, '0);
    expect_period("R7 following", 4, 0, -1, '0);
    stop_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disable();
    t_asym(2, 1);
    t_asym(0, 5);
    t_asym(9, 0);
    t_asym(256, 3);
    t_mid_write();
    t_edge_write();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule